// File: doc/BRIEF.md
# Serial EEPROM Two-Wire Bus Slave

This block is the bus-facing engine of a 2 KB serial EEPROM. It runs on the system clock and oversamples the two-wire clock and data lines. Each line passes through a two-flop synchronizer and a glitch filter. The block then finds Start and Stop conditions and clock edges. It shifts in a control byte, checks the fixed device code and returns an acknowledge. The block-select field of the control byte and the following word-address byte together form an 11-bit byte address. Because that field is part of the address, only one such device can sit on a bus.

Each written data byte goes out on the memory write port as a one-cycle strobe. Within one transaction, successive bytes advance only the low four address bits, so a burst wraps inside its 16-byte page. A Stop that ends a transaction in which data was written raises a one-cycle commit pulse for the write-cycle controller. That controller answers with a busy level. While busy is high, the block acknowledges nothing.

Reads start at the current address pointer and shift out MSB first. The pointer advances across the full 11 bits after each byte. A missing acknowledge from the master ends the read. The open-drain data output changes only a programmable number of system clocks after the filtered bus clock falls.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset, and before any Start, the block drives nothing (`sda_oe` = 0). Bytes clocked without a preceding Start receive no acknowledge.
- R2: A first byte after Start whose upper nibble is not 4'b1010 gets no acknowledge. Every later byte up to the next Start is also ignored and causes no write.
- R3: An accepted byte is acknowledged by holding the data line low for the whole high phase of the ninth clock.
- R4: On a write, control-byte bits [3:1] become address bits [10:8] and the next byte becomes bits [7:0]. Each following data byte gives exactly one `mem_we` pulse carrying that address and byte.
- R5: Successive data bytes in one write advance address bits [3:0] modulo 16, while bits [10:4] stay fixed.
- R6: A Stop raises `wr_commit` for one cycle only if the transaction wrote at least one data byte. An address-only write or a read gives no pulse.
- R7: A control byte with bit 0 = 1 starts a read at the current pointer, MSB first. The pointer then increments after each byte and wraps from 0x7FF to 0x000.
- R8: When the master does not acknowledge a read byte, the block releases the data line and drives nothing more until the next Start.
- R9: While `busy_i` is high, no byte (control, address or data) is acknowledged and no `mem_we` pulse occurs.
- R10: A Start that arrives without a preceding Stop returns the block to expecting a control byte.
- R11: `sda_oe` changes only while the filtered clock is low, and no earlier than HOLD_CYC system clocks after the clock falls.
- R12: A pulse on either line shorter than FILT_CYC system clocks is rejected and cannot form a Start or Stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad (wired value) |
| sda_oe | output | 1 | 1 pulls the data line low; 0 releases it |
| mem_raddr | output | 11 | Read address (current pointer) |
| mem_rdata | input | 8 | Read data for `mem_raddr` |
| mem_we | output | 1 | One-cycle write strobe per received data byte |
| mem_waddr | output | 11 | Write address, valid with `mem_we` |
| mem_wdata | output | 8 | Write data, valid with `mem_we` |
| wr_commit | output | 1 | One-cycle pulse at a Stop that ends a write with data |
| busy_i | input | 1 | Write cycle in progress; suppresses all acknowledges |

## Verification
The acknowledge decision at the end of a byte can fall in the same cycle as a change of `busy_i`. A Start condition can fall in the same window as a byte boundary. The bench raises busy during the reception of a data byte, so it is high at the decision edge. It then judges a missing acknowledge and the absence of any write strobe. A repeated Start is issued right after an acknowledged address byte. The bench judges that the next byte is taken as a control byte: the write lands at the address formed by the new block bits, and there is no stray write at the old pointer.

// File: rtl/eep_i2c_pkg.sv
// Shared types for the serial EEPROM bus slave.
// Assumes: nothing beyond IEEE 1800-2017.
package eep_i2c_pkg;

    // Engine phase within a transfer.
    typedef enum logic [2:0] {
        ST_IDLE,    // ignoring the bus until a Start
        ST_RX,      // shifting in a byte
        ST_RX_ACK,  // driving our acknowledge
        ST_TX,      // shifting out a read byte
        ST_TX_ACK   // sampling the master's acknowledge
    } eng_state_t;

    // Meaning of the next received byte.
    typedef enum logic [1:0] {
        K_CTRL,
        K_ADDR,
        K_DATA
    } byte_kind_t;

endpackage

// File: rtl/i2c_glitch_filter.sv
// Two-flop synchronizer followed by a persistence filter.
// The output takes a new level only after the synchronized input has held it
// for FILT_CYC consecutive clocks, so shorter pulses are dropped.
// Assumes: FILT_CYC >= 2; the line idles high.
module i2c_glitch_filter #(
    parameter int FILT_CYC = 13
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);
    localparam int CW = $clog2(FILT_CYC);
    localparam logic [CW-1:0] LIMIT = CW'(FILT_CYC - 1);

    logic [1:0]    sync_q;
    logic [CW-1:0] run_q;

    // Bring the asynchronous line into the clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], din};
    end

    // Accept a level change only once it has persisted long enough.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dout  <= 1'b1;
            run_q <= '0;
        end else if (sync_q[1] == dout) begin
            run_q <= '0;
        end else if (run_q == LIMIT) begin
            dout  <= sync_q[1];
            run_q <= '0;
        end else begin
            run_q <= run_q + CW'(1);
        end
    end
endmodule

// File: rtl/i2c_bus_events.sv
// Turns filtered clock/data levels into one-cycle event strobes:
// Start, Stop, clock rise and clock fall.
// Assumes: both inputs come through filters of equal latency.
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_ev,
    output logic stop_ev,
    output logic rise_ev,
    output logic fall_ev
);
    logic scl_q, sda_q;

    // Remember the previous levels for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    // Data edges with the clock held high are bus conditions.
    assign start_ev = scl_f & scl_q & sda_q & ~sda_f;
    assign stop_ev  = scl_f & scl_q & ~sda_q & sda_f;
    assign rise_ev  = scl_f & ~scl_q;
    assign fall_ev  = ~scl_f & scl_q;
endmodule

// File: rtl/i2c_sda_hold.sv
// Output stage of the open-drain data line. Each clock fall restarts a
// countdown; only when it expires is the engine's requested level copied to
// the pad enable, so the line never moves near a clock edge.
// Assumes: HOLD_CYC >= 2 and well below the clock low time.
module i2c_sda_hold #(
    parameter int HOLD_CYC = 76
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fall_ev,
    input  logic want_low,
    output logic sda_oe
);
    localparam int HW = $clog2(HOLD_CYC + 1);

    logic [HW-1:0] wait_q;

    // Count down from each clock fall, then apply the requested level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wait_q <= '0;
            sda_oe <= 1'b0;
        end else if (fall_ev) begin
            wait_q <= HW'(HOLD_CYC);
        end else if (wait_q != '0) begin
            wait_q <= wait_q - HW'(1);
            if (wait_q == HW'(1)) sda_oe <= want_low;
        end
    end
endmodule

// File: rtl/eep_i2c_engine.sv
// Byte-level protocol engine: control byte check, address capture, write
// strobes with page roll, sequential reads and acknowledge decisions.
// All decisions are taken on event strobes; want_low is the requested
// level of the data line, applied later by the hold stage.
// Assumes: mem_rdata is valid for ptr_o well before the clock fall that
// loads a read byte; ADDR_W > 8.
module eep_i2c_engine
    import eep_i2c_pkg::*;
#(
    parameter int         ADDR_W   = 11,
    parameter int         PAGE_W   = 4,
    parameter logic [3:0] DEV_CODE = 4'b1010
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              rise_ev,
    input  logic              fall_ev,
    input  logic              sda_s,
    input  logic              busy_i,
    input  logic [7:0]        rdata,
    output logic [ADDR_W-1:0] ptr_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] waddr_o,
    output logic [7:0]        wdata_o,
    output logic              commit_o,
    output logic              want_low
);
    localparam int BLK_W = ADDR_W - 8;

    eng_state_t        st;
    byte_kind_t        kind;
    logic [3:0]        bit_n;
    logic [7:0]        sr;
    logic [ADDR_W-1:0] ptr;
    logic              is_rd, wrote, byte_ok;

    assign ptr_o = ptr;

    // A finished byte is accepted when idle and, for a control byte, coded right.
    assign byte_ok = ~busy_i & ((kind != K_CTRL) | (sr[7:4] == DEV_CODE));

    // Protocol sequencing; bus conditions take priority over bit events.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st       <= ST_IDLE;
            kind     <= K_CTRL;
            bit_n    <= '0;
            sr       <= '0;
            ptr      <= '0;
            is_rd    <= 1'b0;
            wrote    <= 1'b0;
            we_o     <= 1'b0;
            waddr_o  <= '0;
            wdata_o  <= '0;
            commit_o <= 1'b0;
            want_low <= 1'b0;
        end else begin
            we_o     <= 1'b0;
            commit_o <= 1'b0;
            if (start_ev) begin
                st       <= ST_RX;
                kind     <= K_CTRL;
                bit_n    <= '0;
                want_low <= 1'b0;
            end else if (stop_ev) begin
                st       <= ST_IDLE;
                want_low <= 1'b0;
                commit_o <= wrote;
                wrote    <= 1'b0;
            end else begin
                unique case (st)
                    ST_RX: begin
                        if (rise_ev) begin
                            sr    <= {sr[6:0], sda_s};
                            bit_n <= bit_n + 4'd1;
                        end else if (fall_ev && bit_n == 4'd8) begin
                            if (byte_ok) begin
                                want_low <= 1'b1;
                                st       <= ST_RX_ACK;
                                unique case (kind)
                                    K_CTRL: begin
                                        is_rd <= sr[0];
                                        if (!sr[0]) ptr[ADDR_W-1 -: BLK_W] <= sr[BLK_W:1];
                                    end
                                    K_ADDR: ptr[7:0] <= sr;
                                    default: begin
                                        we_o    <= 1'b1;
                                        waddr_o <= ptr;
                                        wdata_o <= sr;
                                        ptr[PAGE_W-1:0] <= ptr[PAGE_W-1:0] + PAGE_W'(1);
                                        wrote   <= 1'b1;
                                    end
                                endcase
                            end else begin
                                st       <= ST_IDLE;
                                want_low <= 1'b0;
                            end
                        end
                    end
                    ST_RX_ACK: begin
                        if (fall_ev) begin
                            bit_n <= '0;
                            if (kind == K_CTRL && is_rd) begin
                                st       <= ST_TX;
                                sr       <= {rdata[6:0], 1'b0};
                                want_low <= ~rdata[7];
                            end else begin
                                st       <= ST_RX;
                                want_low <= 1'b0;
                                kind     <= (kind == K_CTRL) ? K_ADDR : K_DATA;
                            end
                        end
                    end
                    ST_TX: begin
                        if (rise_ev) begin
                            bit_n <= bit_n + 4'd1;
                        end else if (fall_ev) begin
                            if (bit_n == 4'd8) begin
                                want_low <= 1'b0;
                                st       <= ST_TX_ACK;
                                ptr      <= ptr + {{(ADDR_W-1){1'b0}}, 1'b1};
                            end else begin
                                want_low <= ~sr[7];
                                sr       <= {sr[6:0], 1'b0};
                            end
                        end
                    end
                    ST_TX_ACK: begin
                        if (rise_ev && sda_s) begin
                            st <= ST_IDLE;
                        end else if (fall_ev) begin
                            st       <= ST_TX;
                            bit_n    <= '0;
                            sr       <= {rdata[6:0], 1'b0};
                            want_low <= ~rdata[7];
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/eep_i2c_slave.sv
// Top of the serial EEPROM bus slave: line filters, bus event detection,
// protocol engine and delayed open-drain output.
// Assumes: pads are sampled by clk; the write-cycle controller consumes
// mem_we / wr_commit and reports busy_i.
module eep_i2c_slave #(
    parameter int ADDR_W   = 11,
    parameter int PAGE_W   = 4,
    parameter int FILT_CYC = 13,
    parameter int HOLD_CYC = 76
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [ADDR_W-1:0] mem_raddr,
    input  logic [7:0]        mem_rdata,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_waddr,
    output logic [7:0]        mem_wdata,
    output logic              wr_commit,
    input  logic              busy_i
);
    logic [1:0] raw, filt;
    logic       scl_f, sda_f;
    logic       start_ev, stop_ev, rise_ev, fall_ev, want_low;

    assign raw   = {sda_i, scl_i};
    assign scl_f = filt[0];
    assign sda_f = filt[1];

    // One identical filter per bus line.
    for (genvar g = 0; g < 2; g++) begin : g_line
        i2c_glitch_filter #(.FILT_CYC(FILT_CYC)) u_flt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw[g]),
            .dout (filt[g])
        );
    end

    i2c_bus_events u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .scl_f   (scl_f),
        .sda_f   (sda_f),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev)
    );

    eep_i2c_engine #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_eng (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_ev(start_ev),
        .stop_ev (stop_ev),
        .rise_ev (rise_ev),
        .fall_ev (fall_ev),
        .sda_s   (sda_f),
        .busy_i  (busy_i),
        .rdata   (mem_rdata),
        .ptr_o   (mem_raddr),
        .we_o    (mem_we),
        .waddr_o (mem_waddr),
        .wdata_o (mem_wdata),
        .commit_o(wr_commit),
        .want_low(want_low)
    );

    i2c_sda_hold #(.HOLD_CYC(HOLD_CYC)) u_out (
        .clk     (clk),
        .rst_n   (rst_n),
        .fall_ev (fall_ev),
        .want_low(want_low),
        .sda_oe  (sda_oe)
    );
endmodule

// File: rtl/eep_i2c_checker.sv
// Property checker for the serial EEPROM bus slave, bound to the top.
// Assumes: synchronous active-low reset shared with the design.
module eep_i2c_checker #(
    parameter int ADDR_W = 11,
    parameter int PAGE_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy_i,
    input logic              sda_oe,
    input logic              scl_f,
    input logic              stop_ev,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_waddr,
    input logic [ADDR_W-1:0] mem_raddr,
    input logic              wr_commit
);
    AST_OE_MOVES_CLK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f); // R11
    AST_NO_WRITE_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !$past(busy_i)); // R9
    AST_WRITE_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we); // R4
    AST_PAGE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_raddr[ADDR_W-1:PAGE_W] == mem_waddr[ADDR_W-1:PAGE_W])); // R5
    AST_COMMIT_AT_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        wr_commit |-> $past(stop_ev)); // R6
endmodule

bind eep_i2c_slave eep_i2c_checker #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busy_i   (busy_i),
    .sda_oe   (sda_oe),
    .scl_f    (scl_f),
    .stop_ev  (stop_ev),
    .mem_we   (mem_we),
    .mem_waddr(mem_waddr),
    .mem_raddr(mem_raddr),
    .wr_commit(wr_commit)
);

// File: tb/tb_eep_i2c_slave.sv
// Self-checking bench: a bus master model, a byte memory and a table of
// single-byte writes, followed by directed corner-case tests.
module tb_eep_i2c_slave;
    localparam int FILT = 3;
    localparam int HOLD = 8;
    localparam int H    = 40;   // bus clock half period in system clocks

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1, busy = 1'b0;
    logic sda_line, sda_oe, mem_we, wr_commit;
    logic [10:0] mem_raddr, mem_waddr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic [7:0]  bmem [0:2047];
    logic [10:0] we_addr [0:63];
    logic [7:0]  we_data [0:63];
    int we_n = 0, commit_n = 0, n_chk = 0, n_fail = 0;
    int since_fall = 0, oe_viol = 0, oe_moves = 0;
    logic oe_prev = 1'b0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    assign sda_line  = sda_m & ~sda_oe;
    assign mem_rdata = bmem[mem_raddr];

    eep_i2c_slave #(.FILT_CYC(FILT), .HOLD_CYC(HOLD)) dut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .mem_raddr(mem_raddr), .mem_rdata(mem_rdata), .mem_we(mem_we),
        .mem_waddr(mem_waddr), .mem_wdata(mem_wdata), .wr_commit(wr_commit),
        .busy_i(busy)
    );

    // Memory model and write/commit logging.
    always @(posedge clk) begin
        if (mem_we) begin
            bmem[mem_waddr] <= mem_wdata;
            we_addr[we_n[5:0]] <= mem_waddr;
            we_data[we_n[5:0]] <= mem_wdata;
            we_n <= we_n + 1;
        end
        if (wr_commit) commit_n <= commit_n + 1;
    end

    // R11 monitor: output moves only with the clock low and after the hold.
    always @(negedge clk) begin
        if (scl) since_fall <= 0;
        else     since_fall <= since_fall + 1;
        if (rst_n && sda_oe != oe_prev) begin
            oe_moves <= oe_moves + 1;
            if (scl || since_fall < HOLD) oe_viol <= oe_viol + 1;
        end
        oe_prev <= sda_oe;
    end

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic bus_start();
        sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H);
        sda_m = 1'b0; wt(H); scl = 1'b0; wt(H/2);
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; wt(H/2); scl = 1'b1; wt(H); sda_m = 1'b1; wt(H);
    endtask

    // Send one byte; ack is 1 when the line is low across the ninth high phase.
    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit a1, a2;
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
        end
        sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(2);
        a1 = !sda_line; wt(H-4); a2 = !sda_line; wt(2);
        scl = 1'b0; wt(H/2);
        ack = a1 & a2;
    endtask

    task automatic recv_byte(input bit give_ack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            sda_m = 1'b1; wt(H/2); scl = 1'b1; wt(H/2);
            b[i] = sda_line; wt(H/2); scl = 1'b0; wt(H/2);
        end
        sda_m = !give_ack; wt(H/2); scl = 1'b1; wt(H); scl = 1'b0; wt(H/2);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
        $finish;
    endtask

    // Single-byte writes: {block[2:0], address[7:0], data[7:0]}.
    localparam logic [18:0] VEC [6] = '{
        {3'd7, 8'hFE, 8'h3C}, {3'd7, 8'hFF, 8'hC5}, {3'd0, 8'h00, 8'h81},
        {3'd2, 8'h5A, 8'h00}, {3'd4, 8'hA5, 8'hFF}, {3'd1, 8'h33, 8'h6E}
    };

    initial begin
        bit a0, a1, a2;
        logic [7:0] rb;
        int w0, c0;
        wt(5); rst_n = 1'b1; wt(2);
        // R1 reset state
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
        chk(mem_we == 1'b0 && wr_commit == 1'b0, "R1 reset strobes", mem_we, 0);

        // R1 byte without Start is not acknowledged
        send_byte(8'hA0, a0);
        chk(!a0, "R1 no start no ack", a0, 0);
        bus_stop();

        // R12 short low pulse on data while clock high is no Start
        sda_m = 1'b0; wt(FILT-1); sda_m = 1'b1; wt(H);
        send_byte(8'hA0, a0);
        chk(!a0, "R12 glitch rejected", a0, 0);
        bus_stop();

        // Table walk: R3 R4 R6
        for (int i = 0; i < 6; i++) begin
            w0 = we_n; c0 = commit_n;
            bus_start();
            send_byte({4'hA, VEC[i][18:16], 1'b0}, a0);
            send_byte(VEC[i][15:8], a1);
            send_byte(VEC[i][7:0], a2);
            bus_stop(); wt(4);
            chk(a0 && a1 && a2, "R3 ack on write bytes", {a0, a1, a2}, 7);
            chk(we_n == w0 + 1, "R4 one write strobe", we_n - w0, 1);
            chk(we_addr[w0[5:0]] == VEC[i][18:8], "R4 write address", we_addr[w0[5:0]], VEC[i][18:8]);
            chk(we_data[w0[5:0]] == VEC[i][7:0], "R4 write data", we_data[w0[5:0]], VEC[i][7:0]);
            chk(commit_n == c0 + 1, "R6 commit at stop", commit_n - c0, 1);
        end

        // R5 page roll: 18 bytes from 0x50E
        w0 = we_n; c0 = commit_n;
        bus_start();
        send_byte(8'hAA, a0);
        send_byte(8'h0E, a1);
        for (int i = 0; i < 18; i++) begin
            send_byte(8'h80 + 8'(i), a2);
            chk(a2, "R3 page byte ack", a2, 1);
        end
        bus_stop(); wt(4);
        chk(we_n == w0 + 18, "R5 strobe count", we_n - w0, 18);
        for (int i = 0; i < 18; i++) begin
            logic [10:0] ea;
            ea = {7'h50, 4'(4'hE + i)};
            chk(we_addr[(w0 + i) % 64] == ea, "R5 page address", we_addr[(w0 + i) % 64], ea);
        end
        chk(commit_n == c0 + 1, "R6 single commit", commit_n - c0, 1);

        // R6 address-only write sets pointer, no commit
        w0 = we_n; c0 = commit_n;
        bus_start(); send_byte(8'hAE, a0); send_byte(8'hFE, a1); bus_stop(); wt(4);
        chk(commit_n == c0 && we_n == w0, "R6 no commit without data", commit_n - c0, 0);

        // R7 sequential read with wrap, R8 release after NACK
        bus_start();
        send_byte(8'hA1, a0);
        chk(a0, "R7 read control ack", a0, 1);
        recv_byte(1'b1, rb); chk(rb == 8'h3C, "R7 read 0x7FE", rb, 8'h3C);
        recv_byte(1'b1, rb); chk(rb == 8'hC5, "R7 read 0x7FF", rb, 8'hC5);
        recv_byte(1'b0, rb); chk(rb == 8'h81, "R7 read wraps to 0x000", rb, 8'h81);
        wt(H);
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        scl = 1'b1; wt(H/2);
        chk(sda_line == 1'b1, "R8 line high for stop", sda_line, 1);
        scl = 1'b0; wt(H/2);
        bus_stop(); wt(4);
        chk(commit_n == c0, "R6 no commit after read", commit_n - c0, 0);

        // R9 busy: control byte refused
        busy = 1'b1;
        bus_start(); send_byte(8'hA0, a0); bus_stop();
        chk(!a0, "R9 busy control nack", a0, 0);
        busy = 1'b0;
        // R9 busy rising during a data byte
        w0 = we_n; c0 = commit_n;
        bus_start(); send_byte(8'hA0, a0); send_byte(8'h10, a1);
        busy = 1'b1;
        send_byte(8'h55, a2);
        busy = 1'b0;
        bus_stop(); wt(4);
        chk(a0 && a1 && !a2, "R9 busy data nack", {a0, a1, a2}, 6);
        chk(we_n == w0 && commit_n == c0, "R9 no write while busy", we_n - w0, 0);

        // R2 bad device code, then bytes ignored
        w0 = we_n;
        bus_start(); send_byte(8'h30, a0); send_byte(8'hA0, a1); send_byte(8'h00, a2);
        bus_stop(); wt(4);
        chk(!a0, "R2 bad code nack", a0, 0);
        chk(!a1 && !a2, "R2 later bytes ignored", {a1, a2}, 0);
        chk(we_n == w0, "R2 no write", we_n - w0, 0);

        // R10 repeated Start returns to control byte
        w0 = we_n;
        bus_start(); send_byte(8'hA0, a0); send_byte(8'h10, a1);
        bus_start(); send_byte(8'hA6, a2);
        chk(a0 && a1 && a2, "R10 acks around restart", {a0, a1, a2}, 7);
        send_byte(8'h20, a1); send_byte(8'h77, a2);
        bus_stop(); wt(4);
        chk(we_n == w0 + 1, "R10 single write", we_n - w0, 1);
        chk(we_addr[w0[5:0]] == 11'h320, "R10 address from new control", we_addr[w0[5:0]], 11'h320);
        chk(we_data[w0[5:0]] == 8'h77, "R10 data", we_data[w0[5:0]], 8'h77);

        // R11 output timing over the whole run
        chk(oe_viol == 0, "R11 output timing", oe_viol, 0);
        chk(oe_moves > 0, "R11 output active", oe_moves, 1);

        done = 1'b1;
        finish_run();
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            finish_run();
        end
    end
endmodule